// File: doc/BRIEF.md
# I2C Master Byte Clock Generator with Acknowledge Control

This block produces the SCL clock for the master side of an I2C link, running from a 4 MHz system clock. An 8-bit control word holds a 5-bit divider code, a speed-mode select, an acknowledge-value bit and an acknowledge-clock enable. The code and the mode together set the SCL period. One speed setting uses an unequal low/high duty; every other setting uses equal halves.

A start-byte strobe frames one byte. The block sends eight data clocks, most significant bit first. When the acknowledge clock is enabled, a ninth clock follows. In the data phase the block drives SDA from the byte when it is transmitting and releases SDA when it is receiving. On the ninth clock the transmitter releases SDA and captures the receiver's acknowledge. When the block is the receiver, it pulls SDA low or leaves it high. That choice comes from the acknowledge-value bit, or, for an address byte, from the live address-match flag. Both lines are open-drain enables, so 1 means pull low. Writing the control word at any time restarts the clock generator and abandons a byte in flight.

Top module: `i2c_byte_clocker`

## Requirements
- R1: After reset the control word is 0, scl_oe, sda_oe, byte_done and ack_rx are 0, and cfg_err is 1 because code 0 is not allowed.
- R2: Control bits are ack_clk = bit 7, nak = bit 6, fast = bit 5 and code = bits 4..0. In standard mode codes 0 to 4 are illegal; in fast mode codes 0 to 2 are illegal. While an illegal code is loaded, cfg_err is 1, SCL stays released and start_byte is ignored.
- R3: In standard mode each SCL low phase and each high phase lasts 4×code system clocks.
- R4: In fast mode each phase lasts 2×code clocks. The exception is code 5, which gives a 6-clock low phase and a 4-clock high phase.
- R5: A byte has 9 SCL pulses when ack_clk is 1 and 8 pulses when it is 0. The first low phase begins in the cycle after start_byte is taken.
- R6: When transmitting (rx_mode = 0), during the high phase of data pulse i (i = 0..7) sda_oe equals the inverse of tx_byte bit 7−i. sda_oe never changes while SCL is released within a byte.
- R7: When transmitting, sda_oe is 0 during the ninth pulse, and ack_rx captures sda_in at the middle of that pulse's high phase.
- R8: When receiving (rx_mode = 1), sda_oe is 0 on the data pulses. On the ninth pulse sda_oe equals the inverse of nak.
- R9: When receiving an address byte (addr_phase = 1), sda_oe on the ninth pulse is addr_match if nak = 0, and 0 if nak = 1.
- R10: byte_done is a single-cycle pulse in the cycle after the last high phase ends, and SCL then remains released.
- R11: A control write during a byte ends it: from the next cycle scl_oe and sda_oe are 0, and no byte_done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| start_byte | input | 1 | Start one byte frame |
| tx_byte | input | 8 | Byte to send, latched at start |
| rx_mode | input | 1 | 1 = this side receives the byte, latched at start |
| addr_phase | input | 1 | 1 = byte is an address byte, latched at start |
| addr_match | input | 1 | Address comparison result, used live on the ninth clock |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| ack_rx | output | 1 | SDA level captured on the ninth clock |
| byte_done | output | 1 | One-cycle pulse when the byte frame ends |
| cfg_err | output | 1 | Loaded divider code is illegal for the mode |

## Verification
The assertions assume the control word changes only through ctrl_we, and that tx_byte, rx_mode and addr_phase matter only at the start strobe. They also assume addr_match is steady around the ninth clock's low phase. The bench holds every data input constant for the whole of a byte and changes them only while the block is idle. The one exception is the deliberate mid-byte control write that tests the abort.

// File: rtl/i2c_clk_pkg.sv
package i2c_clk_pkg;

    localparam int CODE_W        = 5;
    localparam int CNT_W         = CODE_W + 2;
    localparam int DATA_BITS     = 8;
    localparam int IDX_W         = 4;

    localparam logic [CODE_W-1:0] STD_MIN_CODE  = CODE_W'(5);
    localparam logic [CODE_W-1:0] FAST_MIN_CODE = CODE_W'(3);
    localparam logic [CODE_W-1:0] SKEW_CODE     = CODE_W'(5);
    localparam logic [CNT_W-1:0]  SKEW_LOW      = CNT_W'(6);
    localparam logic [CNT_W-1:0]  SKEW_HIGH     = CNT_W'(4);

    // control word, MSB first: ack clock, nak, fast, code
    typedef struct packed {
        logic              ack_clk;
        logic              nak;
        logic              fast;
        logic [CODE_W-1:0] code;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] low_len;
        logic [CNT_W-1:0] high_len;
        logic             ok;
    } rate_t;

    function automatic rate_t decode_rate(ctrl_t c);
        rate_t            r;
        logic [CNT_W-1:0] c_ext;
        c_ext = CNT_W'(c.code);
        if (c.fast) begin
            r.ok = (c.code >= FAST_MIN_CODE);
            if (c.code == SKEW_CODE) begin
                r.low_len  = SKEW_LOW;
                r.high_len = SKEW_HIGH;
            end else begin
                r.low_len  = c_ext << 1;
                r.high_len = c_ext << 1;
            end
        end else begin
            r.ok       = (c.code >= STD_MIN_CODE);
            r.low_len  = c_ext << 2;
            r.high_len = c_ext << 2;
        end
        return r;
    endfunction

    // pull-low decision for the ninth clock
    function automatic logic ack_pull(logic rx, logic addr, logic match, logic nak);
        if (!rx || nak) return 1'b0;
        if (addr)       return match;
        return 1'b1;
    endfunction

endpackage

// File: rtl/i2c_ctrl_rate.sv
module i2c_ctrl_rate
    import i2c_clk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [7:0]  wdata,
    output ctrl_t       ctrl,
    output rate_t       rate
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= '0;
        else if (we) ctrl_q <= ctrl_t'(wdata);
    end

    assign ctrl = ctrl_q;

    always_comb rate = decode_rate(ctrl_q);

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
    import i2c_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    output logic             scl_high,
    output logic             mid_low,
    output logic             mid_high,
    output logic             high_end
);
    logic [CNT_W-1:0] cnt_q;
    logic             high_q;
    logic [CNT_W-1:0] cur_len;

    assign cur_len = high_q ? high_len : low_len;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            high_q <= 1'b0;
        end else if (cnt_q == cur_len - CNT_W'(1)) begin
            cnt_q  <= '0;
            high_q <= ~high_q;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign scl_high = high_q;
    assign mid_low  = run && !high_q && (cnt_q == (low_len  >> 1));
    assign mid_high = run &&  high_q && (cnt_q == (high_len >> 1));
    assign high_end = run &&  high_q && (cnt_q == high_len - CNT_W'(1));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < cur_len));

    assert_phase_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(high_end)) |-> !high_q);

endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
    import i2c_clk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 abort,
    input  logic                 start,
    input  logic                 rate_ok,
    input  ctrl_t                ctrl,
    input  logic [DATA_BITS-1:0] tx_byte,
    input  logic                 rx_mode,
    input  logic                 addr_phase,
    input  logic                 addr_match,
    input  logic                 sda_in,
    input  logic                 scl_high,
    input  logic                 mid_low,
    input  logic                 mid_high,
    input  logic                 high_end,
    output logic                 busy,
    output logic                 sda_oe,
    output logic                 ack_rx,
    output logic                 byte_done
);
    localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(DATA_BITS);
    localparam logic [IDX_W-1:0] LAST_DAT = IDX_W'(DATA_BITS - 1);

    logic                 busy_q, sda_q, ack_q, done_q;
    logic                 rx_q, addr_q;
    logic [IDX_W-1:0]     idx_q, last_q;
    logic [DATA_BITS-1:0] sh_q;
    logic                 take;
    logic                 in_ack;

    assign take   = start && !busy_q && rate_ok && !abort;
    assign in_ack = (idx_q == ACK_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sda_q  <= 1'b0;
            ack_q  <= 1'b0;
            done_q <= 1'b0;
            rx_q   <= 1'b0;
            addr_q <= 1'b0;
            idx_q  <= '0;
            last_q <= LAST_DAT;
            sh_q   <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            sda_q  <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (take) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                last_q <= ctrl.ack_clk ? ACK_IDX : LAST_DAT;
                sh_q   <= tx_byte;
                rx_q   <= rx_mode;
                addr_q <= addr_phase;
            end else if (busy_q) begin
                if (mid_low) begin
                    if (in_ack) sda_q <= ack_pull(rx_q, addr_q, addr_match, ctrl.nak);
                    else        sda_q <= rx_q ? 1'b0 : ~sh_q[DATA_BITS-1];
                end
                if (mid_high && in_ack) ack_q <= sda_in;
                if (high_end) begin
                    if (idx_q == last_q) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                        sh_q  <= {sh_q[DATA_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign busy      = busy_q;
    assign sda_oe    = sda_q;
    assign ack_rx    = ack_q;
    assign byte_done = done_q;

    assert_sda_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && scl_high && $past(busy_q && scl_high)) |-> $stable(sda_q));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);

    assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q <= last_q));

endmodule

// File: rtl/i2c_byte_clocker.sv
module i2c_byte_clocker
    import i2c_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       start_byte,
    input  logic [7:0] tx_byte,
    input  logic       rx_mode,
    input  logic       addr_phase,
    input  logic       addr_match,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       ack_rx,
    output logic       byte_done,
    output logic       cfg_err
);
    ctrl_t ctrl;
    rate_t rate;
    logic  busy, scl_high, mid_low, mid_high, high_end;

    i2c_ctrl_rate u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .ctrl  (ctrl),
        .rate  (rate)
    );

    i2c_phase_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .low_len  (rate.low_len),
        .high_len (rate.high_len),
        .scl_high (scl_high),
        .mid_low  (mid_low),
        .mid_high (mid_high),
        .high_end (high_end)
    );

    i2c_byte_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .abort      (ctrl_we),
        .start      (start_byte),
        .rate_ok    (rate.ok),
        .ctrl       (ctrl),
        .tx_byte    (tx_byte),
        .rx_mode    (rx_mode),
        .addr_phase (addr_phase),
        .addr_match (addr_match),
        .sda_in     (sda_in),
        .scl_high   (scl_high),
        .mid_low    (mid_low),
        .mid_high   (mid_high),
        .high_end   (high_end),
        .busy       (busy),
        .sda_oe     (sda_oe),
        .ack_rx     (ack_rx),
        .byte_done  (byte_done)
    );

    assign scl_oe  = busy && !scl_high;
    assign cfg_err = !rate.ok;

    assert_err_idle_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);

    assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (!scl_oe && !byte_done));

endmodule

// File: tb/test_i2c_byte_clocker.sv
module test_i2c_byte_clocker;

    localparam int CLK_PERIOD = 250;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       start_byte = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       rx_mode = 1'b0;
    logic       addr_phase = 1'b0;
    logic       addr_match = 1'b0;
    logic       sda_in = 1'b1;
    logic       scl_oe, sda_oe, ack_rx, byte_done, cfg_err;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_byte_clocker i_i2c_byte_clocker (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .start_byte(start_byte), .tx_byte(tx_byte), .rx_mode(rx_mode),
        .addr_phase(addr_phase), .addr_match(addr_match), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .ack_rx(ack_rx),
        .byte_done(byte_done), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // one full byte frame with per-pulse checks
    task automatic run_byte(input logic [7:0] cfg, input logic [7:0] data,
                            input bit rx, input bit addr, input bit match,
                            input bit ack_line);
        int code, lo, hi, n, lc, hc, exp_sda;
        bit fast, nak;
        code = int'(cfg[4:0]); fast = cfg[5]; nak = cfg[6];
        n  = cfg[7] ? 9 : 8;
        lo = fast ? ((code == 5) ? 6 : 2*code) : 4*code;
        hi = fast ? ((code == 5) ? 4 : 2*code) : 4*code;
        tx_byte = data; rx_mode = rx; addr_phase = addr;
        addr_match = match; sda_in = ack_line;
        @(negedge clk); start_byte = 1'b1;
        @(negedge clk); start_byte = 1'b0;
        for (int p = 0; p < n; p++) begin
            lc = 0;
            while (scl_oe === 1'b1 && lc < 400) begin lc++; @(negedge clk); end
            exp_sda = 0;
            if (p < 8) exp_sda = rx ? 0 : int'(~data[7-p]);
            else if (rx) exp_sda = addr ? int'(!nak && match) : int'(!nak);
            // R6 R8 R9: value seen on SDA while SCL released
            check(sda_oe === exp_sda[0], p < 8 ? (rx ? "R8" : "R6") : (addr ? "R9" : (rx ? "R8" : "R7")),
                  int'(sda_oe), exp_sda);
            hc = 0;
            while (scl_oe === 1'b0 && byte_done !== 1'b1 && hc < 400) begin hc++; @(negedge clk); end
            check(lc == lo, fast ? "R4 low" : "R3 low", lc, lo);
            check(hc == hi, fast ? "R4 high" : "R3 high", hc, hi);
            if (p == n-1) check(byte_done === 1'b1, "R5 R10 done after last pulse", int'(byte_done), 1);
            else          check(byte_done === 1'b0, "R5 no early done", int'(byte_done), 0);
        end
        @(negedge clk);
        check(byte_done === 1'b0 && scl_oe === 1'b0, "R10 single pulse, SCL released",
              int'({byte_done, scl_oe}), 0);
        if (n == 9) check(ack_rx === ack_line, "R7 ack captured", int'(ack_rx), int'(ack_line));
    endtask

    task automatic expect_silent(input int cyc, input string req);
        int seen;
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (scl_oe !== 1'b0 || byte_done !== 1'b0) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(CLK_PERIOD*190000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(scl_oe === 1'b0, "R1 scl_oe", int'(scl_oe), 0);
        check(sda_oe === 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        check(byte_done === 1'b0, "R1 byte_done", int'(byte_done), 0);
        check(ack_rx === 1'b0, "R1 ack_rx", int'(ack_rx), 0);
        check(cfg_err === 1'b1, "R1 cfg_err", int'(cfg_err), 1);

        // R2 illegal codes: error flag and ignored start
        for (int c = 0; c < 5; c++) begin
            write_ctrl(8'(c));
            check(cfg_err === 1'b1, "R2 std illegal", int'(cfg_err), 1);
            @(negedge clk); start_byte = 1'b1; @(negedge clk); start_byte = 1'b0;
            expect_silent(40, "R2 start ignored std");
        end
        for (int c = 0; c < 3; c++) begin
            write_ctrl(8'h20 | 8'(c));
            check(cfg_err === 1'b1, "R2 fast illegal", int'(cfg_err), 1);
            @(negedge clk); start_byte = 1'b1; @(negedge clk); start_byte = 1'b0;
            expect_silent(40, "R2 start ignored fast");
        end

        // R3 R5 R6 R7: standard sweep, transmit with ack clock
        for (int c = 5; c < 32; c++) begin
            write_ctrl(8'h80 | 8'(c));
            check(cfg_err === 1'b0, "R2 std legal", int'(cfg_err), 0);
            run_byte(8'h80 | 8'(c), 8'(c*37) ^ 8'hA5, 1'b0, 1'b0, 1'b0, c[0]);
        end

        // R4 R5 R8: fast sweep, receive, no ack clock
        for (int c = 3; c < 32; c++) begin
            write_ctrl(8'h20 | 8'(c));
            check(cfg_err === 1'b0, "R2 fast legal", int'(cfg_err), 0);
            run_byte(8'h20 | 8'(c), 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1);
        end

        // skewed fast setting with each acknowledge variant
        write_ctrl(8'hA5);
        run_byte(8'hA5, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);   // R7 tx, ack low
        run_byte(8'hA5, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);   // R7 tx, ack high
        run_byte(8'hA5, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0);   // R8 rx, nak=0
        run_byte(8'hA5, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0);   // R9 match
        run_byte(8'hA5, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b1);   // R9 mismatch
        write_ctrl(8'hE5);
        run_byte(8'hE5, 8'h81, 1'b1, 1'b0, 1'b0, 1'b1);   // R8 nak=1
        run_byte(8'hE5, 8'h81, 1'b1, 1'b1, 1'b1, 1'b1);   // R9 nak=1 overrides match

        // R11 abort by control write mid byte
        write_ctrl(8'h8A);
        tx_byte = 8'h00; rx_mode = 1'b0;
        @(negedge clk); start_byte = 1'b1; @(negedge clk); start_byte = 1'b0;
        repeat (100) @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = 8'h8A;
        @(negedge clk); ctrl_we = 1'b0;
        check(scl_oe === 1'b0, "R11 scl released", int'(scl_oe), 0);
        check(sda_oe === 1'b0, "R11 sda released", int'(sda_oe), 0);
        expect_silent(800, "R11 no activity or done");
        run_byte(8'h8A, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);   // R11 restart works

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule